// File: doc/BRIEF.md
# SPI Transfer Engine with Delayed Receive Sampling

This block runs SPI transfers on behalf of a command stream. Each 16-bit command arrives on a valid/ready channel. A transfer command starts a burst of one or more words. The block drives the serial clock and an active-low chip select, and shifts transmit words out MSB first. Transmit words come in on their own valid/ready stream. The block also captures one word per receive line in parallel. When a word completes, all the captured words are presented together on a valid-only output.

A signal coming back from a remote device can arrive late because of board and pad delay. To allow for this, the receive sampling point can be moved back by a fixed number of core clock cycles (parameter `SDI_DELAY`). The nominal sampling point is the sampling edge of the serial clock. The delayed sample of the last bit can therefore land after the serial clock has stopped. For that reason, the transmit-enable and receive-enable flags of a transfer are captured when the command is accepted. The block uses those stored flags until the next transfer command, not the live command bus. It also holds the chip select low until every pending delayed sample has been taken.

Top module: `spi_xfer_engine`

## Requirements
- R1: A command with bits [15:12] equal to 0 is a transfer of (bits [7:0] + 1) words of DATA_WIDTH bits each. Any other opcode is accepted (cmd_ready high) and causes no serial activity.
- R2: Bit 9 (receive enable) and bit 8 (transmit enable) are stored when a transfer command is accepted. Changes on cmd_data after acceptance, including a new command waiting with cmd_valid high, do not affect the running transfer.
- R3: With transmit enabled, each accepted tx_data word is shifted out MSB first on spi_sdo. The bit is present in the first core cycle in which spi_sclk is high.
- R4: spi_sclk idles low and is never high while spi_cs_n is high. Each high phase lasts exactly DIV+1 core cycles and each low phase lasts at least DIV+1 cycles.
- R5: Suppose spi_sclk is first high in core cycle c. Then the receive lines are sampled on the core clock edge that closes cycle c+SDI_DELAY.
- R6: After the last bit of a word is sampled with receive enabled, rx_valid is high for exactly the next cycle. rx_data[i*DATA_WIDTH +: DATA_WIDTH] then holds line i, with the first sampled bit as the MSB. This holds even when the sample falls after the serial clock has stopped.
- R7: With transmit disabled, spi_sdo stays 0 during the transfer and tx_ready is never asserted.
- R8: With receive disabled, rx_valid is never asserted for that transfer.
- R9: spi_cs_n is high in reset and when idle. It goes low before the first rising spi_sclk and stays low until every delayed sample of the transfer has been taken. cmd_ready is high only while no transfer is in progress.
- R10: While a transmit word is awaited (tx_ready high, tx_valid low), spi_sclk holds low and the transfer resumes without losing bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_data | input | 16 | Command word |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Engine takes a transmit word |
| tx_data | input | DATA_WIDTH | Transmit word |
| rx_valid | output | 1 | Received words valid (one cycle) |
| rx_data | output | NUM_OF_SDI*DATA_WIDTH | Received words, one per receive line |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sdo | output | 1 | Serial data out |
| spi_sdi | input | NUM_OF_SDI | Serial data in, one bit per line |

## Verification
The bench drives a new random value on every receive line in every core cycle. A delay line aligned one cycle early or one cycle late therefore shifts in the neighbouring bits, and the captured words come out wrong. The default delay is longer than a serial clock high phase, so the last sample of every transfer falls after the clock has stopped. A design that dropped that strobe, or released the chip select too early, would lose the final rx_valid. One test queues a second command with different flags while the first transfer is still running. A design that followed the live command bus would then emit receive words for a transfer that had receive disabled. Transmit stalls, transfers with both directions disabled and non-transfer opcodes check that the clock waits correctly, that no transmit words are consumed when they should not be, and that nothing happens on the serial pins when nothing should.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_DRAIN
  } xfer_state_e;

  localparam logic [3:0] OP_XFER = 4'h0;
endpackage

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_WIDTH = 8,
  parameter int DIV        = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [15:0]           cmd_data,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [DATA_WIDTH-1:0] tx_data,
  input  logic                  pipe_busy,
  output logic                  en_sdi,
  output logic                  strobe,
  output logic                  strobe_last,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  sdo
);
  localparam int              BIT_W    = (DATA_WIDTH > 1) ? $clog2(DATA_WIDTH) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_WIDTH - 1);
  localparam logic [7:0]      HALF_END = 8'(DIV);

  xfer_state_e           state_q, state_d;
  logic [7:0]            cnt_q, cnt_d;
  logic                  ph_q, ph_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [7:0]            words_q, words_d;
  logic [DATA_WIDTH-1:0] tx_q, tx_d;
  logic                  en_sdi_q, en_sdi_d, en_sdo_q, en_sdo_d;
  logic                  cs_n_q, cs_n_d;
  logic                  stb_q, stb_d, stb_last_q, stb_last_d;
  logic                  half_end, is_xfer;
  logic                  unused_cmd_bits;

  assign unused_cmd_bits = ^cmd_data[11:10];
  assign half_end  = (cnt_q == HALF_END);
  assign is_xfer   = (cmd_data[15:12] == OP_XFER);
  assign cmd_ready = (state_q == ST_IDLE);
  assign tx_ready  = (state_q == ST_LOAD) && en_sdo_q;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    ph_d       = ph_q;
    bit_d      = bit_q;
    words_d    = words_q;
    tx_d       = tx_q;
    en_sdi_d   = en_sdi_q;
    en_sdo_d   = en_sdo_q;
    cs_n_d     = cs_n_q;
    stb_d      = 1'b0;
    stb_last_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid && is_xfer) begin
          en_sdi_d = cmd_data[9];
          en_sdo_d = cmd_data[8];
          words_d  = cmd_data[7:0];
          state_d  = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (!en_sdo_q || tx_valid) begin
          tx_d    = en_sdo_q ? tx_data : '0;
          cnt_d   = '0;
          ph_d    = 1'b0;
          bit_d   = '0;
          cs_n_d  = 1'b0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (half_end) begin
          cnt_d = '0;
          ph_d  = ~ph_q;
          if (!ph_q) begin
            stb_d      = 1'b1;
            stb_last_d = (bit_q == LAST_BIT);
          end else if (bit_q == LAST_BIT) begin
            bit_d = '0;
            if (words_q == 8'd0) begin
              state_d = ST_DRAIN;
            end else begin
              words_d = words_q - 8'd1;
              state_d = ST_LOAD;
            end
          end else begin
            bit_d = bit_q + 1'b1;
            tx_d  = {tx_q[DATA_WIDTH-2:0], 1'b0};
          end
        end else begin
          cnt_d = cnt_q + 8'd1;
        end
      end
      ST_DRAIN: begin
        if (!pipe_busy) begin
          cs_n_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      ph_q       <= 1'b0;
      bit_q      <= '0;
      words_q    <= '0;
      tx_q       <= '0;
      en_sdi_q   <= 1'b0;
      en_sdo_q   <= 1'b0;
      cs_n_q     <= 1'b1;
      stb_q      <= 1'b0;
      stb_last_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      ph_q       <= ph_d;
      bit_q      <= bit_d;
      words_q    <= words_d;
      tx_q       <= tx_d;
      en_sdi_q   <= en_sdi_d;
      en_sdo_q   <= en_sdo_d;
      cs_n_q     <= cs_n_d;
      stb_q      <= stb_d;
      stb_last_q <= stb_last_d;
    end
  end

  assign en_sdi      = en_sdi_q;
  assign strobe      = stb_q;
  assign strobe_last = stb_last_q;
  assign sclk        = ph_q;
  assign cs_n        = cs_n_q;
  assign sdo         = tx_q[DATA_WIDTH-1];

  // R2: stored flags move only while idle
  a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(en_sdi_q) && $stable(en_sdo_q)));

  // R9: chip select stays asserted while delayed samples are pending
  a_r9_cs_during_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && pipe_busy) |=> !cs_n_q);

  // R4: no clock activity outside chip select
  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !ph_q);

  // R7: disabled transmit keeps the data line at zero
  a_r7_sdo_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_sdo_q && (state_q == ST_RUN || state_q == ST_DRAIN)) |-> !tx_q[DATA_WIDTH-1]);
endmodule

// File: rtl/spi_rx_capture.sv
module spi_rx_capture #(
  parameter int DATA_WIDTH = 8,
  parameter int NUM_OF_SDI = 2,
  parameter int SDI_DELAY  = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             strobe,
  input  logic                             strobe_last,
  input  logic                             en_sdi,
  input  logic [NUM_OF_SDI-1:0]            sdi,
  output logic                             busy,
  output logic                             rx_valid,
  output logic [NUM_OF_SDI*DATA_WIDTH-1:0] rx_data
);
  logic tap_stb, tap_last;
  logic valid_q;

  generate
    if (SDI_DELAY == 0) begin : g_nodly
      assign tap_stb  = strobe;
      assign tap_last = strobe_last;
      assign busy     = 1'b0;
    end else begin : g_dly
      logic [SDI_DELAY-1:0] stb_q, stb_d, last_q, last_d;
      always_comb begin
        stb_d[0]  = strobe;
        last_d[0] = strobe_last;
        for (int i = 1; i < SDI_DELAY; i++) begin
          stb_d[i]  = stb_q[i-1];
          last_d[i] = last_q[i-1];
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stb_q  <= '0;
          last_q <= '0;
        end else begin
          stb_q  <= stb_d;
          last_q <= last_d;
        end
      end
      assign tap_stb  = stb_q[SDI_DELAY-1];
      assign tap_last = last_q[SDI_DELAY-1];
      assign busy     = |stb_q;
    end
  endgenerate

  for (genvar g = 0; g < NUM_OF_SDI; g++) begin : g_line
    logic [DATA_WIDTH-1:0] sh_q, sh_d, word_q;
    assign sh_d = {sh_q[DATA_WIDTH-2:0], sdi[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        word_q <= '0;
      end else begin
        if (tap_stb) sh_q <= sh_d;
        if (tap_stb && tap_last) word_q <= sh_d;
      end
    end
    assign rx_data[g*DATA_WIDTH +: DATA_WIDTH] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= tap_stb && tap_last && en_sdi;
  end

  assign rx_valid = valid_q;

  // R6: each completed word gives a single-cycle pulse
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5: a delayed sample never lands while the strobe line is empty
  a_r5_tap_from_line: assert property (@(posedge clk) disable iff (!rst_n)
    tap_last |-> tap_stb);
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
  parameter int DATA_WIDTH = 8,
  parameter int NUM_OF_SDI = 2,
  parameter int SDI_DELAY  = 3,
  parameter int DIV        = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cmd_valid,
  output logic                             cmd_ready,
  input  logic [15:0]                      cmd_data,
  input  logic                             tx_valid,
  output logic                             tx_ready,
  input  logic [DATA_WIDTH-1:0]            tx_data,
  output logic                             rx_valid,
  output logic [NUM_OF_SDI*DATA_WIDTH-1:0] rx_data,
  output logic                             spi_sclk,
  output logic                             spi_cs_n,
  output logic                             spi_sdo,
  input  logic [NUM_OF_SDI-1:0]            spi_sdi
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       pipe_busy, en_sdi, strobe, strobe_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  spi_seq_ctrl #(
    .DATA_WIDTH(DATA_WIDTH),
    .DIV       (DIV)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_data   (cmd_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .pipe_busy  (pipe_busy),
    .en_sdi     (en_sdi),
    .strobe     (strobe),
    .strobe_last(strobe_last),
    .sclk       (spi_sclk),
    .cs_n       (spi_cs_n),
    .sdo        (spi_sdo)
  );

  spi_rx_capture #(
    .DATA_WIDTH(DATA_WIDTH),
    .NUM_OF_SDI(NUM_OF_SDI),
    .SDI_DELAY (SDI_DELAY)
  ) u_capture (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .strobe     (strobe),
    .strobe_last(strobe_last),
    .en_sdi     (en_sdi),
    .sdi        (spi_sdi),
    .busy       (pipe_busy),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data)
  );
endmodule

// File: tb/spi_xfer_engine_tb.sv
module spi_xfer_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int NSDI = 2;
  localparam int DLY  = 3;
  localparam int DIV  = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_ready;
  logic [15:0] cmd_data;
  logic tx_valid, tx_ready;
  logic [DW-1:0] tx_data;
  logic rx_valid;
  logic [NSDI*DW-1:0] rx_data;
  logic spi_sclk, spi_cs_n, spi_sdo;
  logic [NSDI-1:0] spi_sdi;

  int tests = 0;
  int fails = 0;

  // reference model state
  int  cyc = 0;
  int  stall_until = 0;
  bit  en_sdi_m = 0, en_sdo_m = 0;
  bit  prev_sclk = 0;
  int  hi_len = 0, lo_len = 0;
  int  rises = 0, hs_count = 0, tx_idx = 0;
  bit  hs_pend = 0;
  int  due_q[$];
  bit  exp_bits[$];
  int  nbits = 0;
  int  exp_valid_cyc = -1;
  logic [DW-1:0] rx_m [NSDI];
  logic [NSDI*DW-1:0] exp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_xfer_engine #(
    .DATA_WIDTH(DW), .NUM_OF_SDI(NSDI), .SDI_DELAY(DLY), .DIV(DIV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_sdo(spi_sdo), .spi_sdi(spi_sdi)
  );

  function automatic logic [DW-1:0] tx_word(input int i);
    return DW'((i * 91) ^ 195);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic model_step();
    bit expb;
    bit expv;
    cyc++;
    if (hs_pend) begin
      tx_idx++;
      tx_data = tx_word(tx_idx);
      hs_pend = 0;
    end
    tx_valid = (cyc >= stall_until);
    if (tx_valid && tx_ready) begin
      hs_pend = 1;
      hs_count++;
      for (int b = DW - 1; b >= 0; b--) exp_bits.push_back(tx_data[b]);
    end
    if (tx_ready) chk(en_sdo_m, "R7 tx_ready with transmit off", 1, 0);
    if (tx_ready && !tx_valid) chk(!spi_sclk, "R10 clock held during stall", spi_sclk, 0);
    if (spi_cs_n) begin
      chk(!spi_sclk, "R4 sclk low when deselected", spi_sclk, 0);
      lo_len = 0;
    end
    if (spi_sclk && !prev_sclk) begin
      rises++;
      chk(!spi_cs_n, "R9 cs low at clock rise", spi_cs_n, 0);
      chk(lo_len >= DIV + 1, "R4 low phase length", lo_len, DIV + 1);
      if (en_sdo_m) begin
        if (exp_bits.size() == 0) begin
          chk(0, "R3 bit without transmit word", spi_sdo, 0);
          expb = 0;
        end else begin
          expb = exp_bits.pop_front();
          chk(spi_sdo == expb, "R3 sdo bit", spi_sdo, expb);
        end
      end else begin
        chk(spi_sdo == 1'b0, "R7 sdo zero", spi_sdo, 0);
      end
      due_q.push_back(cyc + DLY);
      hi_len = 0;
    end
    if (!spi_sclk && prev_sclk) begin
      chk(hi_len == DIV + 1, "R4 high phase length", hi_len, DIV + 1);
      lo_len = 0;
    end
    if (spi_sclk) hi_len++;
    else if (!spi_cs_n) lo_len++;
    expv = (cyc == exp_valid_cyc);
    if (rx_valid !== expv)
      chk(0, en_sdi_m ? "R6 rx_valid timing" : "R8 rx_valid with receive off", rx_valid, expv);
    if (rx_valid && expv) chk(rx_data == exp_data, "R5/R6 rx_data", rx_data, exp_data);
    for (int i = 0; i < NSDI; i++) spi_sdi[i] = 1'($urandom);
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      void'(due_q.pop_front());
      chk(!spi_cs_n, "R9 cs low at delayed sample", spi_cs_n, 0);
      for (int i = 0; i < NSDI; i++) rx_m[i] = {rx_m[i][DW-2:0], spi_sdi[i]};
      nbits++;
      if (nbits == DW) begin
        nbits = 0;
        if (en_sdi_m) begin
          exp_valid_cyc = cyc + 1;
          for (int i = 0; i < NSDI; i++) exp_data[i*DW +: DW] = rx_m[i];
        end
      end
    end
    prev_sclk = spi_sclk;
  endtask

  initial begin
    spi_sdi  = '0;
    tx_valid = 1'b0;
    tx_data  = tx_word(0);
    for (int i = 0; i < NSDI; i++) rx_m[i] = '0;
    exp_data = '0;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      model_step();
    end
  end

  task automatic send_cmd(input logic [15:0] d);
    cmd_data  = d;
    cmd_valid = 1'b1;
    while (cmd_ready !== 1'b1) @(negedge clk);
    if (d[15:12] == 4'h0) begin
      en_sdi_m = d[9];
      en_sdo_m = d[8];
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = d ^ 16'h0300;
  endtask

  task automatic wait_done();
    while (spi_cs_n) @(negedge clk);
    while (!spi_cs_n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic end_checks(input int r0, input int h0, input int words, input int tx_words);
    chk(rises - r0 == words * DW, "R1 clock rises per transfer", rises - r0, words * DW);
    chk(hs_count - h0 == tx_words, "R3/R7 transmit words taken", hs_count - h0, tx_words);
    chk(exp_bits.size() == 0, "R3 transmit bits all sent", exp_bits.size(), 0);
    chk(exp_valid_cyc < cyc, "R6 last word delivered", exp_valid_cyc, cyc);
  endtask

  initial begin
    int r0, h0;
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_data  = '0;
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R9 cs high in reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R4 sclk low in reset", spi_sclk, 0);
    chk(rx_valid == 1'b0, "R6 no rx_valid in reset", rx_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_ready == 1'b1, "R9 ready when idle", cmd_ready, 1);
    chk(tx_ready == 1'b0, "R7 no tx_ready when idle", tx_ready, 0);

    // single word, both directions
    r0 = rises; h0 = hs_count;
    send_cmd(16'h0300);
    wait_done();
    end_checks(r0, h0, 1, 1);

    // R2: transmit-only transfer, then a receive-only command waits on the bus
    r0 = rises; h0 = hs_count;
    send_cmd(16'h0102);
    send_cmd(16'h0201);
    wait_done();
    end_checks(r0, h0, 5, 3);

    // both directions disabled
    r0 = rises; h0 = hs_count;
    send_cmd(16'h0000);
    wait_done();
    end_checks(r0, h0, 1, 0);

    // R1: non-transfer opcode causes nothing
    r0 = rises;
    send_cmd(16'h7303);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!spi_cs_n) chk(0, "R1 cs moved on non-transfer", spi_cs_n, 1);
    end
    chk(spi_cs_n == 1'b1, "R1 cs idle after non-transfer", spi_cs_n, 1);
    chk(rises == r0, "R1 no clock on non-transfer", rises - r0, 0);

    // R10: transmit stall
    r0 = rises; h0 = hs_count;
    stall_until = cyc + 25;
    send_cmd(16'h0301);
    wait_done();
    end_checks(r0, h0, 2, 2);

    // longer burst
    r0 = rises; h0 = hs_count;
    send_cmd(16'h0310);
    wait_done();
    end_checks(r0, h0, 17, 17);

    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule